// File: doc/BRIEF.md
# Masked Input-Change Interrupt Unit

This block watches the pins of a 40-pin general-purpose I/O expander, grouped as five banks of eight, and signals an interrupt when an input has moved away from the value that software last read. Each pin level goes through a two-flop synchroniser. The synchronised level is then compared with a captured input register. A pin counts towards the interrupt only when two conditions hold: its direction bit marks it as an input, and its mask bit is clear.

A read of a bank is signalled by a one-cycle strobe. The strobe recaptures that bank's eight synchronised levels and removes the bank's contribution to the interrupt. Other banks keep their pending state. A pin that returns to its captured level before anyone reads it stops contributing on its own. The interrupt output drives the enable of an active-low open-drain pull-down. The mask bits are loaded one bank at a time and come out of reset all set, so every pin starts masked.

Top module: `gci_top`

## Requirements
- R1: A synchronous active-high reset clears `irq_oe` and every bit of `cap_q`, and sets all mask bits to 1. After reset, with no mask write, no pin activity raises `irq_oe`.
- R2: A pin change reaches `irq_oe` on the third rising edge after it is applied: two synchroniser stages plus the output register.
- R3: `irq_oe` = 1 (pull the line low) when at least one unmasked input pin has a synchronised level that differs from its bit in `cap_q`. Otherwise `irq_oe` is 0.
- R4: A pin whose mask bit is 1 never raises `irq_oe`, whatever its level does.
- R5: A pin whose `dir_in` bit is 0 (output) never raises `irq_oe`. A `dir_in` bit of 1 marks an input.
- R6: `rd_strobe[b]` loads the synchronised levels of pins b*8..b*8+7 into `cap_q[b*8 +: 8]` at that edge. While its strobe is low, a bank's bits in `cap_q` hold their value.
- R7: A read removes that bank's contribution, so `irq_oe` is low after the read edge unless another bank is still pending. Pending banks that were not read keep `irq_oe` high.
- R8: If a pin returns to its captured level before the bank is read, its contribution clears by itself.
- R9: A synchronised change that lands on the same edge as its bank's read is not lost. The read captures the older level, `irq_oe` is low for one cycle, and then it rises on the following edge.
- R10: `mask_wr_en[b]` loads `mask_wr_data[i]` into the mask bit of pin b*8+i. A mask bit of 1 masks the pin and 0 enables it. Mask bits of banks whose enable is low are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 40 | Asynchronous pin levels |
| dir_in | input | 40 | Per-pin direction, 1 = input |
| mask_wr_en | input | 5 | Per-bank mask write strobe |
| mask_wr_data | input | 8 | Mask byte for the written bank(s) |
| rd_strobe | input | 5 | Per-bank input-register read pulse |
| cap_q | output | 40 | Captured input register |
| irq_oe | output | 1 | Open-drain pull-down enable for the active-low interrupt |

## Verification
The delicate overlap is a read strobe arriving on the same edge at which a newly synchronised pin level reaches the comparator. The capture then takes the pre-change level, and the clear must not swallow the new difference. The bench provokes this by changing a pin one cycle before pulsing its bank's read. It then expects `cap_q` to hold the old level, `irq_oe` to be low just after the read, and `irq_oe` to be high one edge later. A second overlap, a read of one bank while another bank stays pending, is judged by `irq_oe` remaining high until the second bank is read.

// File: rtl/gci_pkg.sv
package gci_pkg;
  localparam int DEF_BANKS  = 5;
  localparam int DEF_BANK_W = 8;
  localparam int DEF_SYNC   = 2;

  // direction bit encoding
  typedef enum logic {
    PIN_OUT = 1'b0,
    PIN_IN  = 1'b1
  } pin_dir_e;
endpackage

// File: rtl/gci_sync.sv
module gci_sync #(
  parameter int W      = 40,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) st[s] <= '0;
    end else begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gci_bank.sv
module gci_bank
  import gci_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] dir,
  input  logic         rd,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wd,
  output logic [W-1:0] cap_q,
  output logic [W-1:0] mask_q,
  output logic         pend
);
  logic [W-1:0] live;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      mask_q <= '1;
    end else begin
      if (rd)      cap_q  <= pin_s;
      if (mask_we) mask_q <= mask_wd;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++)
      live[i] = (pin_s[i] != cap_q[i]) && (dir[i] == PIN_IN) && !mask_q[i];
  end

  // a read on this edge withdraws the bank's contribution
  assign pend = (|live) && !rd;
endmodule

// File: rtl/gci_irq_out.sv
module gci_irq_out #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend,
  output logic         irq_oe
);
  always_ff @(posedge clk) begin
    if (rst) irq_oe <= 1'b0;
    else     irq_oe <= |pend;
  end
endmodule

// File: rtl/gci_top.sv
module gci_top
  import gci_pkg::*;
#(
  parameter int BANKS  = DEF_BANKS,
  parameter int BANK_W = DEF_BANK_W,
  parameter int SYNC   = DEF_SYNC
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BANKS*BANK_W-1:0]   pin_in,
  input  logic [BANKS*BANK_W-1:0]   dir_in,
  input  logic [BANKS-1:0]          mask_wr_en,
  input  logic [BANK_W-1:0]         mask_wr_data,
  input  logic [BANKS-1:0]          rd_strobe,
  output logic [BANKS*BANK_W-1:0]   cap_q,
  output logic                      irq_oe
);
  localparam int PINS = BANKS * BANK_W;

  logic [PINS-1:0]  pin_s;
  logic [PINS-1:0]  mask_q;
  logic [BANKS-1:0] pend;
  logic             mask_all;

  gci_sync #(.W(PINS), .STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    gci_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .pin_s   (pin_s[b*BANK_W +: BANK_W]),
      .dir     (dir_in[b*BANK_W +: BANK_W]),
      .rd      (rd_strobe[b]),
      .mask_we (mask_wr_en[b]),
      .mask_wd (mask_wr_data),
      .cap_q   (cap_q[b*BANK_W +: BANK_W]),
      .mask_q  (mask_q[b*BANK_W +: BANK_W]),
      .pend    (pend[b])
    );
  end

  gci_irq_out #(.N(BANKS)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .pend   (pend),
    .irq_oe (irq_oe)
  );

  assign mask_all = &mask_q;
endmodule

// File: rtl/gci_top_chk.sv
module gci_top_chk #(
  parameter int BANKS  = 5,
  parameter int BANK_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [BANKS*BANK_W-1:0] dir_in,
  input logic [BANKS-1:0]        rd_strobe,
  input logic [BANKS*BANK_W-1:0] cap_q,
  input logic                    irq_oe,
  input logic [BANKS*BANK_W-1:0] pin_s,
  input logic                    mask_all
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!irq_oe && cap_q == '0));

  // R4
  all_masked_chk: assert property (@(posedge clk) disable iff (rst) mask_all |=> !irq_oe);

  // R5
  all_output_chk: assert property (@(posedge clk) disable iff (rst) (dir_in == '0) |=> !irq_oe);

  // R7
  read_all_clear_chk: assert property (@(posedge clk) disable iff (rst) (&rd_strobe) |=> !irq_oe);

  // R6
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst) (rd_strobe == '0) |=> $stable(cap_q));

  for (genvar b = 0; b < BANKS; b++) begin : g_cap
    // R6
    cap_load_chk: assert property (@(posedge clk) disable iff (rst)
      rd_strobe[b] |=> cap_q[b*BANK_W +: BANK_W] == $past(pin_s[b*BANK_W +: BANK_W]));
  end
endmodule

bind gci_top gci_top_chk #(.BANKS(BANKS), .BANK_W(BANK_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dir_in    (dir_in),
  .rd_strobe (rd_strobe),
  .cap_q     (cap_q),
  .irq_oe    (irq_oe),
  .pin_s     (pin_s),
  .mask_all  (mask_all)
);

// File: tb/gci_top_test.sv
`timescale 1ns/100ps
module gci_top_test;
  localparam int NB = 5;
  localparam int BW = 8;
  localparam int NP = NB * BW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] dir_in = '1;
  logic [NB-1:0] mask_wr_en = '0;
  logic [BW-1:0] mask_wr_data = '0;
  logic [NB-1:0] rd_strobe = '0;
  logic [NP-1:0] cap_q;
  logic          irq_oe;

  int total = 0;
  int bad = 0;
  logic [NP-1:0] m_cap  = '0;
  logic [NP-1:0] m_mask = '1;

  localparam logic [NP-1:0] VEC [8] = '{
    40'h00_0000_0001, 40'h80_0000_0001, 40'h80_0000_0001, 40'h00_FF00_0000,
    40'hAA_55AA_55AA, 40'hAA_55AA_55AA, 40'h00_0000_0000, 40'hFF_FFFF_FFFF
  };

  gci_top uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .dir_in(dir_in),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .rd_strobe(rd_strobe), .cap_q(cap_q), .irq_oe(irq_oe)
  );

  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return |((pin_in ^ m_cap) & dir_in & ~m_mask);
  endfunction

  task automatic rd_banks(input logic [NB-1:0] which);
    rd_strobe = which;
    tick(1);
    rd_strobe = '0;
    for (int b = 0; b < NB; b++)
      if (which[b]) m_cap[b*BW +: BW] = pin_in[b*BW +: BW];
  endtask

  task automatic wr_mask(input logic [NB-1:0] which, input logic [BW-1:0] val);
    mask_wr_en = which;
    mask_wr_data = val;
    tick(1);
    mask_wr_en = '0;
    for (int b = 0; b < NB; b++)
      if (which[b]) m_mask[b*BW +: BW] = val;
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R1 irq after reset", irq_oe, 0);
    chk("R1 cap after reset", cap_q, 0);

    // default masks hide any change
    pin_in = '1;
    tick(4);
    chk("R1/R4 default masked", irq_oe, 0);

    // R10: enable bank 2 only
    wr_mask(5'b00100, 8'h00);
    tick(3);
    chk("R10 bank2 unmasked raises", irq_oe, 1);
    wr_mask(5'b00100, 8'hFF);
    tick(3);
    chk("R4 remask clears", irq_oe, 0);

    // unmask everything, clean slate
    wr_mask('1, 8'h00);
    pin_in = '0;
    tick(4);
    rd_banks('1);
    chk("R7 read all", irq_oe, 0);

    // table walk
    for (int k = 0; k < 8; k++) begin
      pin_in = VEC[k];
      tick(4);
      chk($sformatf("R3 vec%0d irq", k), irq_oe, exp_irq());
      rd_banks('1);
      chk($sformatf("R6 vec%0d cap", k), cap_q, VEC[k]);
      chk($sformatf("R7 vec%0d clear", k), irq_oe, 0);
    end

    // R2: latency
    pin_in = 40'h00_0000_0010;
    tick(2);
    chk("R2 not yet after 2 edges", irq_oe, 0);
    tick(1);
    chk("R2 set after 3 edges", irq_oe, 1);
    rd_banks('1);

    // R5: output pin ignored
    dir_in[5] = 1'b0;
    pin_in[5] = ~pin_in[5];
    tick(4);
    chk("R5 output pin ignored", irq_oe, 0);
    dir_in = '1;
    tick(3);
    chk("R5 becomes input again", irq_oe, 1);
    pin_in[5] = m_cap[5];
    tick(4);

    // R4: single masked pin
    wr_mask(5'b00010, 8'h04);
    pin_in[10] = ~pin_in[10];
    tick(4);
    chk("R4 masked pin10", irq_oe, 0);
    pin_in[10] = m_cap[10];
    wr_mask(5'b00010, 8'h00);
    tick(3);

    // R7: two banks pending, read one at a time
    pin_in[3]  = ~pin_in[3];
    pin_in[35] = ~pin_in[35];
    tick(4);
    chk("R3 two banks pending", irq_oe, 1);
    rd_banks(5'b00001);
    chk("R7 other bank keeps irq", irq_oe, 1);
    chk("R6 bank0 captured", cap_q[7:0], pin_in[7:0]);
    chk("R6 bank4 held", cap_q[39:32], m_cap[39:32]);
    rd_banks(5'b10000);
    chk("R7 last bank clears", irq_oe, 0);
    chk("R6 bank4 captured", cap_q[39:32], pin_in[39:32]);

    // R8: change and return
    pin_in[20] = ~pin_in[20];
    tick(4);
    chk("R8 change seen", irq_oe, 1);
    pin_in[20] = ~pin_in[20];
    tick(4);
    chk("R8 self clear", irq_oe, 0);
    chk("R6 cap untouched", cap_q, m_cap);

    // R9: change lands on read edge
    begin
      logic [BW-1:0] old_b1;
      old_b1 = pin_in[15:8];
      pin_in[12] = ~pin_in[12];
      tick(1);
      rd_strobe = 5'b00010;
      tick(1);
      rd_strobe = '0;
      chk("R9 cap holds old level", cap_q[15:8], old_b1);
      chk("R9 irq low after read", irq_oe, 0);
      tick(1);
      chk("R9 irq rises next edge", irq_oe, 1);
      m_cap[15:8] = old_b1;
      rd_banks(5'b00010);
      chk("R9 second read clears", irq_oe, 0);
    end

    // R1: reset mid-run restores masks and capture
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    chk("R1 reset irq", irq_oe, 0);
    chk("R1 reset cap", cap_q, 0);
    m_cap = '0;
    m_mask = '1;
    pin_in = 40'h12_3456_789A;
    tick(4);
    chk("R1 masks restored", irq_oe, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule